// File: doc/BRIEF.md
# Byte-Loaded Double-Buffered DAC Code Register

This block is the digital front end of a 12-bit current-output converter whose code arrives over an 8-bit parallel bus. Two active-low byte selects and an active-low write strobe place a high or a low byte into a staging (input) register. An active-low load strobe either transfers the staged code into the output (DAC) register, or lets a byte write update both registers in the same operation. Software can therefore stage a full code in two writes and switch the converter to it in one step, or write straight through.

A mode pin and a control pin work together. With the mode pin high (normal operation), the control pin picks how the two bytes are packed into the 12-bit code: left-justified or right-justified. With the mode pin low, the code sent to the converter is forced to all zeros or all ones, chosen by the control pin. The stored registers are left alone, so the held code returns as soon as the mode pin goes high again.

All strobes are sampled on a system clock. A write acts once, in the first clock cycle in which the write strobe is seen low. The reset input is asynchronous and active-low, and its release is synchronised inside the block.

Top module: `dac_byte_front`

## Requirements
- R1: While reset is asserted, and after it is released, both registers hold zero and `dac_code` reads 0x000 in normal mode.
- R2: While `wr_n` is high, no register changes, whatever the selects, `load_n` and the bus do.
- R3: A write with `lo_sel_n`=0, `hi_sel_n`=1 and `load_n`=1 updates only the low part of the input register. `dac_code` does not change.
- R4: A write with `hi_sel_n`=0, `lo_sel_n`=1 and `load_n`=1 updates only the high part of the input register. `dac_code` does not change.
- R5: A single-byte write with `load_n`=0 updates the input register, and the DAC register takes the updated input value in the same clock cycle.
- R6: A write with both selects high and `load_n`=0 copies the whole input register into the DAC register.
- R7: With `norm_mode`=0, `dac_code` is 0x000 when `sel_ctl`=0 and 0xFFF when `sel_ctl`=1.
- R8: The forced code leaves the DAC register unchanged. With `norm_mode`=1, `dac_code` equals the stored DAC register value.
- R9: With `norm_mode`=1 and `sel_ctl`=0 (left-justified), a high-byte write sets code bits 11:4 to bus bits 7:0, and a low-byte write sets code bits 3:0 to bus bits 7:4.
- R10: With `norm_mode`=1 and `sel_ctl`=1 (right-justified), a high-byte write sets code bits 11:8 to bus bits 3:0, and a low-byte write sets code bits 7:0 to bus bits 7:0.
- R11: A write acts only in the first clock cycle in which `wr_n` is seen low. Holding `wr_n` low for more cycles has no further effect.
- R12: Both selects low is not a byte write: the input register is unchanged. If `load_n`=0, the input register is still copied to the DAC register.
- R13: While `norm_mode`=0, byte writes use the justification last selected with `norm_mode`=1. That justification is left-justified after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_n | input | 1 | Active-low write strobe |
| hi_sel_n | input | 1 | Active-low high-byte select |
| lo_sel_n | input | 1 | Active-low low-byte select |
| load_n | input | 1 | Active-low DAC register load |
| norm_mode | input | 1 | 1: normal mode with selectable packing; 0: forced output code |
| sel_ctl | input | 1 | Packing choice (0 left, 1 right) in normal mode; forced level (0 zeros, 1 ones) otherwise |
| bus_data | input | 8 | Parallel data byte |
| dac_code | output | 12 | Code driven to the converter |

## Verification
A byte write and a DAC register load can land in the same cycle. The DAC register must then capture the freshly packed input value, not the old one. Directed cases write each byte with `load_n` low under both packings. Random traffic mixes all strobe combinations with override toggles, and every cycle the output is compared with a bench model that applies the packing first and then the load. The other collision is an override that coincides with a write: the bench holds `norm_mode` low across byte writes, then releases it and checks that the staged code was packed with the justification held from before.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
  typedef enum logic {
    JUST_LEFT  = 1'b0,
    JUST_RIGHT = 1'b1
  } just_e;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2
  } byte_sel_e;
endpackage

// File: rtl/dbf_strobe.sv
module dbf_strobe
  import dbf_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_n,
  input  logic      hi_sel_n,
  input  logic      lo_sel_n,
  input  logic      load_n,
  output logic      wr_fire,
  output byte_sel_e which,
  output logic      dac_load
);
  logic wr_q;
  logic wr_d;

  always_comb begin
    wr_d = wr_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= 1'b1;
    else        wr_q <= wr_d;
  end

  always_comb begin
    wr_fire = wr_q & ~wr_n;
    unique case ({hi_sel_n, lo_sel_n})
      2'b10:   which = SEL_LO;
      2'b01:   which = SEL_HI;
      default: which = SEL_NONE;
    endcase
    dac_load = wr_fire & ~load_n;
  end
endmodule

// File: rtl/dbf_packer.sv
module dbf_packer
  import dbf_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int CODE_W = 12
) (
  input  logic [CODE_W-1:0] cur_code,
  input  logic [BUS_W-1:0]  bus_byte,
  input  byte_sel_e         which,
  input  just_e             just,
  output logic [CODE_W-1:0] new_code
);
  localparam int REM_W = CODE_W - BUS_W;

  always_comb begin
    new_code = cur_code;
    unique case (which)
      SEL_HI: begin
        if (just == JUST_LEFT) new_code = {bus_byte, cur_code[REM_W-1:0]};
        else                   new_code = {bus_byte[REM_W-1:0], cur_code[BUS_W-1:0]};
      end
      SEL_LO: begin
        if (just == JUST_LEFT) new_code = {cur_code[CODE_W-1:REM_W], bus_byte[BUS_W-1 -: REM_W]};
        else                   new_code = {cur_code[CODE_W-1:BUS_W], bus_byte};
      end
      default: new_code = cur_code;
    endcase
  end
endmodule

// File: rtl/dbf_regs.sv
module dbf_regs
  import dbf_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  byte_sel_e         which,
  input  logic              dac_load,
  input  logic [CODE_W-1:0] packed_code,
  input  logic              norm_mode,
  input  logic              sel_ctl,
  output logic [CODE_W-1:0] inp_q,
  output logic [CODE_W-1:0] dac_q,
  output just_e             fmt_q
);
  logic              inp_en;
  logic              dac_en;
  logic              fmt_en;
  logic [CODE_W-1:0] inp_d;
  logic [CODE_W-1:0] dac_d;
  just_e             fmt_d;

  always_comb begin
    inp_en = wr_fire && (which != SEL_NONE);
    inp_d  = packed_code;
    dac_en = dac_load;
    dac_d  = inp_en ? packed_code : inp_q;
    fmt_en = norm_mode;
    fmt_d  = just_e'(sel_ctl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inp_q <= '0;
      dac_q <= '0;
      fmt_q <= JUST_LEFT;
    end else begin
      if (inp_en) inp_q <= inp_d;
      if (dac_en) dac_q <= dac_d;
      if (fmt_en) fmt_q <= fmt_d;
    end
  end
endmodule

// File: rtl/dac_byte_front.sv
module dac_byte_front
  import dbf_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int CODE_W = 12,
  parameter int SYNC_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic              hi_sel_n,
  input  logic              lo_sel_n,
  input  logic              load_n,
  input  logic              norm_mode,
  input  logic              sel_ctl,
  input  logic [BUS_W-1:0]  bus_data,
  output logic [CODE_W-1:0] dac_code
);
  logic [SYNC_W-1:0] rst_pipe;
  logic              rst_int_n;
  logic              wr_fire;
  byte_sel_e         which;
  logic              dac_load;
  just_e             just;
  just_e             fmt_q;
  logic [CODE_W-1:0] packed_code;
  logic [CODE_W-1:0] inp_q;
  logic [CODE_W-1:0] dac_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_W-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_W-1];

  dbf_strobe u_strobe (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_n     (wr_n),
    .hi_sel_n (hi_sel_n),
    .lo_sel_n (lo_sel_n),
    .load_n   (load_n),
    .wr_fire  (wr_fire),
    .which    (which),
    .dac_load (dac_load)
  );

  always_comb begin
    just = norm_mode ? just_e'(sel_ctl) : fmt_q;
  end

  dbf_packer #(.BUS_W(BUS_W), .CODE_W(CODE_W)) u_packer (
    .cur_code (inp_q),
    .bus_byte (bus_data),
    .which    (which),
    .just     (just),
    .new_code (packed_code)
  );

  dbf_regs #(.CODE_W(CODE_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .wr_fire     (wr_fire),
    .which       (which),
    .dac_load    (dac_load),
    .packed_code (packed_code),
    .norm_mode   (norm_mode),
    .sel_ctl     (sel_ctl),
    .inp_q       (inp_q),
    .dac_q       (dac_q),
    .fmt_q       (fmt_q)
  );

  always_comb begin
    if (norm_mode) dac_code = dac_q;
    else           dac_code = {CODE_W{sel_ctl}};
  end
endmodule

// File: rtl/dbf_checker.sv
module dbf_checker #(
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_n,
  input logic              hi_sel_n,
  input logic              lo_sel_n,
  input logic              load_n,
  input logic              norm_mode,
  input logic              sel_ctl,
  input logic [CODE_W-1:0] inp_q,
  input logic [CODE_W-1:0] dac_q,
  input logic [CODE_W-1:0] dac_code
);
  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_clear_chk: assert (inp_q == '0 && dac_q == '0);
    end
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_n |=> ($stable(inp_q) && $stable(dac_q)));

  // R11
  single_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && !$past(wr_n)) |=> ($stable(inp_q) && $stable(dac_q)));

  // R6
  copy_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && $past(wr_n) && hi_sel_n && lo_sel_n && !load_n) |=> (dac_q == $past(inp_q)));

  // R3
  lo_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && hi_sel_n && !lo_sel_n && load_n) |=> $stable(dac_q));

  // R7
  force_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !norm_mode |-> (dac_code == {CODE_W{sel_ctl}}));

  // R8
  pass_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    norm_mode |-> (dac_code == dac_q));
endmodule

bind dac_byte_front dbf_checker #(.CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_n      (wr_n),
  .hi_sel_n  (hi_sel_n),
  .lo_sel_n  (lo_sel_n),
  .load_n    (load_n),
  .norm_mode (norm_mode),
  .sel_ctl   (sel_ctl),
  .inp_q     (inp_q),
  .dac_q     (dac_q),
  .dac_code  (dac_code)
);

// File: tb/test_dac_byte_front.sv
`timescale 1ns/1ps
module test_dac_byte_front;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_n, hi_sel_n, lo_sel_n, load_n, norm_mode, sel_ctl;
  logic [7:0]  bus_data;
  logic [11:0] dac_code;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  // bench model state
  logic [11:0] m_inp, m_dac;
  logic        m_fmt, m_wrprev;

  always #5 clk = ~clk;

  dac_byte_front i_dac_byte_front (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .hi_sel_n(hi_sel_n), .lo_sel_n(lo_sel_n),
    .load_n(load_n), .norm_mode(norm_mode), .sel_ctl(sel_ctl),
    .bus_data(bus_data), .dac_code(dac_code)
  );

  function automatic logic [11:0] pack(input logic [11:0] cur, input logic [7:0] b,
                                       input logic hi, input logic right);
    if (hi) return right ? {b[3:0], cur[7:0]} : {b, cur[3:0]};
    else    return right ? {cur[11:8], b}     : {cur[11:4], b[7:4]};
  endfunction

  function automatic logic [11:0] expect_code();
    return norm_mode ? m_dac : {12{sel_ctl}};
  endfunction

  task automatic check(input string req, input logic [11:0] exp);
    checks++;
    if (dac_code !== exp) begin
      fails++;
      $display("FAIL %s: dac_code=%03h expected=%03h", req, dac_code, exp);
    end
  endtask

  task automatic model_step();
    logic fire, right;
    fire  = !wr_n && m_wrprev;
    right = norm_mode ? sel_ctl : m_fmt;
    if (fire) begin
      if (hi_sel_n != lo_sel_n) m_inp = pack(m_inp, bus_data, !hi_sel_n, right);
      if (!load_n) m_dac = m_inp;
    end
    if (norm_mode) m_fmt = sel_ctl;
    m_wrprev = wr_n;
  endtask

  // at a negedge: drive, pass one posedge, return at the next negedge
  task automatic cyc(input logic w, input logic hs, input logic ls, input logic ld,
                     input logic nm, input logic c, input logic [7:0] d);
    wr_n = w; hi_sel_n = hs; lo_sel_n = ls; load_n = ld; norm_mode = nm; sel_ctl = c; bus_data = d;
    @(posedge clk);
    model_step();
    @(negedge clk);
    cycles++;
  endtask

  // idle cycle releasing the write strobe
  task automatic rel(input logic nm, input logic c);
    cyc(1, 1, 1, 1, nm, c, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0;
    wr_n = 1; hi_sel_n = 1; lo_sel_n = 1; load_n = 1; norm_mode = 1; sel_ctl = 0; bus_data = 0;
    m_inp = 0; m_dac = 0; m_fmt = 0; m_wrprev = 1;
    repeat (3) @(negedge clk);
    check("R1 in reset", 12'h000);
    rst_n = 1'b1;
    repeat (4) rel(1, 0);
    check("R1 after release", 12'h000);

    // left-justified staging
    cyc(0, 0, 1, 1, 1, 0, 8'hAB); check("R4 hi write, no load", 12'h000);
    rel(1, 0);
    cyc(0, 1, 0, 1, 1, 0, 8'hC7); check("R3 lo write, no load", 12'h000);
    rel(1, 0);
    cyc(0, 1, 1, 0, 1, 0, 8'h00); check("R6 copy / R9 left packing", 12'hABC);
    rel(1, 0);

    // R2: strobes active but wr_n high
    cyc(1, 0, 1, 0, 1, 0, 8'h11); check("R2 wr high hi+load", 12'hABC);
    cyc(1, 1, 0, 0, 1, 0, 8'h22); check("R2 wr high lo+load", 12'hABC);
    cyc(0, 1, 1, 0, 1, 0, 8'h00); check("R2 input untouched", 12'hABC);
    rel(1, 0);

    // right-justified write-through
    cyc(0, 0, 1, 0, 1, 1, 8'hF5); check("R5 hi write-through / R10", 12'h5BC);
    rel(1, 1);
    cyc(0, 1, 0, 0, 1, 1, 8'h3C); check("R5 lo write-through / R10", 12'h53C);
    rel(1, 1);

    // R11: hold wr_n low, change bus
    cyc(0, 1, 0, 0, 1, 1, 8'h77); check("R11 first low cycle", 12'h577);
    cyc(0, 1, 0, 0, 1, 1, 8'h99); check("R11 held low, no repeat", 12'h577);
    cyc(0, 0, 1, 0, 1, 1, 8'h0E); check("R11 held low, sel change", 12'h577);
    rel(1, 1);

    // R12: both selects low
    cyc(0, 0, 0, 1, 1, 1, 8'hEE); check("R12 both selects, no load", 12'h577);
    rel(1, 1);
    cyc(0, 0, 0, 0, 1, 1, 8'hDD); check("R12 both selects, load copies", 12'h577);
    rel(1, 1);

    // R7/R8 override
    rel(0, 0); check("R7 forced zeros", 12'h000);
    rel(0, 1); check("R7 forced ones", 12'hFFF);
    rel(1, 1); check("R8 stored value returns", 12'h577);

    // R13: write during override uses held right justification
    rel(0, 0);
    cyc(0, 0, 1, 0, 0, 0, 8'h0A); check("R13 forced during write", 12'h000);
    rel(0, 0);
    rel(1, 1); check("R13 held justification / R8", 12'hA77);
    // held left justification
    rel(1, 0);
    cyc(0, 1, 0, 0, 0, 1, 8'h50); check("R13 forced ones during write", 12'hFFF);
    rel(0, 1);
    rel(1, 0); check("R13 held left justification", 12'hA75);

    // constrained random
    begin
      int unsigned seed;
      seed = $urandom(32'h5eed_1234);
      for (int i = 0; i < 3000; i++) begin
        logic w, nm;
        w  = ($urandom % 3) != 0;
        nm = ($urandom % 5) != 0;
        cyc(w, $urandom % 2, $urandom % 2, $urandom % 2, nm, $urandom % 2, 8'($urandom));
        check(norm_mode ? "R5 random" : "R7 random", expect_code());
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: cycles=%0d expected=done", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule